// File: doc/BRIEF.md
# Twofish 128-bit Key Schedule Generator

This block turns a 128-bit cipher key into the material a Twofish round datapath needs. On a load strobe it stores the key. Over the following eight cycles it runs a Reed-Solomon multiply over GF(2^8) to produce the two 32-bit S-box key words, which are exported for the F function. Once those words are ready, the round controller can ask for any round subkey pair by giving its pair index. The pair is computed from the stored key through the h function in the cycle of the request, and is returned one cycle later with a valid flag. No table of forty subkeys is ever stored.

A new load restarts the derivation at once, even if the previous one is still running. Requests made before the S words are ready are ignored. So are requests for a pair index beyond the last pair.

Top module: `twofish_keysched`

## Requirements
- R1: After reset, `sbox_ready` and `pair_vld` are both low.
- R2: Key byte n (n = 0..15) is `key_in[8n+7:8n]`. Key word M_i is bytes 4i..4i+3 with byte 4i least significant, the even list is (M0, M2) and the odd list is (M1, M3).
- R3: S_i (i = 0, 1) is the 4x8 Reed-Solomon matrix times key bytes 8i..8i+7 over GF(2^8) reduced by 0x14D, with row r giving byte r of S_i (byte 0 least significant). `sbox_words[31:0]` carries S1 and `sbox_words[63:32]` carries S0.
- R4: `sbox_ready` is low in the sample after the load edge and stays low for the next seven edges. It goes high at the eighth clock edge after the edge that samples `key_load`.
- R5: A `key_load` while a derivation is in progress aborts it and restarts the timing of R4. The resulting S words depend only on the newest key.
- R6: A request with index i gives `pair_out[31:0]` = K[2i] = A+B and `pair_out[63:32]` = K[2i+1] = ROL(A+2B, 9), both mod 2^32. A = h(2i·0x01010101, even list) and B = ROL(h((2i+1)·0x01010101, odd list), 8), where h uses the q permutations and an MDS multiply reduced by 0x169.
- R7: `pair_vld` is high only in the cycle after an edge that sampled `pair_req` high. With no request it is low.
- R8: A request with `pair_idx` of 20 or more gives no `pair_vld`.
- R9: A request made while `sbox_ready` is low, or in the same cycle as `key_load`, gives no `pair_vld`.
- R10: While `sbox_ready` is high and no load occurs, `sbox_words` holds its value, whatever the pair requests do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_load | input | 1 | Store `key_in` and restart S-word derivation |
| key_in | input | 128 | Cipher key, byte n at bits 8n+7:8n |
| pair_req | input | 1 | Request a subkey pair |
| pair_idx | input | 5 | Pair index i, 0..19 |
| pair_out | output | 64 | {K[2i+1], K[2i]} |
| pair_vld | output | 1 | `pair_out` holds the requested pair |
| sbox_words | output | 64 | {S0, S1} S-box key words |
| sbox_ready | output | 1 | S words derived for the stored key |

## Verification
The checker watches the control rules on every cycle: the exact eight-cycle latency from load to ready, the clearing of ready and valid after a load, the gating of valid by request, index range and readiness, and the holding of the S words while ready. It cannot judge arithmetic. The bench's scenarios alone show that the S words and the subkey pairs are numerically right, by comparing them against an independent model for several keys and indices, including the first and last pair and a key reloaded partway through a derivation.

// File: rtl/tf_ks_pkg.sv
package tf_ks_pkg;

   // 4-bit permutation tables for the two byte permutations, nibble i at [63-4i -: 4]
   localparam logic [63:0] PA_T0 = 64'h817D6F320B59ECA4;
   localparam logic [63:0] PA_T1 = 64'hECB81235F4A6709D;
   localparam logic [63:0] PA_T2 = 64'hBA5E6D90C8F32471;
   localparam logic [63:0] PA_T3 = 64'hD7F4126E9B3085CA;
   localparam logic [63:0] PB_T0 = 64'h28BDF76E31940AC5;
   localparam logic [63:0] PB_T1 = 64'h1E2B4C376DA5F908;
   localparam logic [63:0] PB_T2 = 64'h4C75169A0ED82B3F;
   localparam logic [63:0] PB_T3 = 64'hB951C3DE647F208A;

   // Reed-Solomon rows, column c at [63-8c -: 8]
   localparam logic [63:0] RS_ROW0 = 64'h01A455875A58DB9E;
   localparam logic [63:0] RS_ROW1 = 64'hA45682F31EC668E5;
   localparam logic [63:0] RS_ROW2 = 64'h02A1FCC147AE3D19;
   localparam logic [63:0] RS_ROW3 = 64'hA455875A58DB9E03;

   // MDS rows, column c at [31-8c -: 8]
   localparam logic [31:0] MX_ROW0 = 32'h01EF5B5B;
   localparam logic [31:0] MX_ROW1 = 32'h5BEFEF01;
   localparam logic [31:0] MX_ROW2 = 32'hEF5B01EF;
   localparam logic [31:0] MX_ROW3 = 32'hEF01EF5B;

   function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b,
                                          input logic [8:0] poly);
      logic [8:0] sh;
      logic [7:0] r;
      sh = {1'b0, a};
      r  = '0;
      for (int i = 0; i < 8; i++) begin
         if (b[i]) r = r ^ sh[7:0];
         sh = {sh[7:0], 1'b0};
         if (sh[8]) sh = sh ^ poly;
      end
      return r;
   endfunction

   function automatic logic [3:0] nib(input logic [63:0] t, input logic [3:0] i);
      return t[(15 - int'(i)) * 4 +: 4];
   endfunction

   function automatic logic [3:0] ror4(input logic [3:0] v);
      return {v[0], v[3:1]};
   endfunction

   // sel = 0: first permutation, sel = 1: second permutation
   function automatic logic [7:0] qperm(input logic sel, input logic [7:0] x);
      logic [63:0] t0, t1, t2, t3;
      logic [3:0]  a1, b1, a2, b2, a3, b3, a4, b4;
      t0 = sel ? PB_T0 : PA_T0;
      t1 = sel ? PB_T1 : PA_T1;
      t2 = sel ? PB_T2 : PA_T2;
      t3 = sel ? PB_T3 : PA_T3;
      a1 = x[7:4] ^ x[3:0];
      b1 = x[7:4] ^ ror4(x[3:0]) ^ {x[4], 3'b000};
      a2 = nib(t0, a1);
      b2 = nib(t1, b1);
      a3 = a2 ^ b2;
      b3 = a2 ^ ror4(b2) ^ {a2[0], 3'b000};
      a4 = nib(t2, a3);
      b4 = nib(t3, b3);
      return {b4, a4};
   endfunction

   function automatic logic [7:0] rs_coef(input int row, input int col);
      logic [63:0] r;
      case (row)
         0:       r = RS_ROW0;
         1:       r = RS_ROW1;
         2:       r = RS_ROW2;
         default: r = RS_ROW3;
      endcase
      return r[(7 - col) * 8 +: 8];
   endfunction

   function automatic logic [31:0] mds_mix(input logic [31:0] y, input logic [8:0] poly);
      logic [31:0] z;
      logic [31:0] row;
      z = '0;
      for (int r = 0; r < 4; r++) begin
         case (r)
            0:       row = MX_ROW0;
            1:       row = MX_ROW1;
            2:       row = MX_ROW2;
            default: row = MX_ROW3;
         endcase
         for (int c = 0; c < 4; c++)
            z[r*8 +: 8] = z[r*8 +: 8] ^ gf_mul(row[(3 - c) * 8 +: 8], y[c*8 +: 8], poly);
      end
      return z;
   endfunction

   function automatic logic [31:0] rol32(input logic [31:0] v, input int n);
      return (v << n) | (v >> (32 - n));
   endfunction

endpackage

// File: rtl/tf_rs_serial.sv
module tf_rs_serial #(
   parameter int         NWORDS = 2,
   parameter int         COLS   = 8,
   parameter logic [8:0] POLY   = 9'h14D
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic [NWORDS*64-1:0]   key_bytes,
   output logic [NWORDS*32-1:0]   s_nat,
   output logic                   done
);
   import tf_ks_pkg::*;

   localparam int CW = (COLS > 1) ? $clog2(COLS) : 1;

   generate
      if (COLS != 8) begin : g_bad_cols
         $error("tf_rs_serial: matrix has exactly 8 columns");
      end
   endgenerate

   logic [CW-1:0]         col;
   logic                  busy;
   logic [NWORDS*32-1:0]  acc;
   logic [NWORDS*32-1:0]  term;

   // one column of the matrix per cycle, for every S word in parallel
   generate
      for (genvar w = 0; w < NWORDS; w++) begin : g_word
         for (genvar r = 0; r < 4; r++) begin : g_row
            always_comb begin
               term[w*32 + r*8 +: 8] = gf_mul(rs_coef(r, int'(col)),
                                              key_bytes[(8*w + int'(col)) * 8 +: 8], POLY);
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         col  <= '0;
         busy <= 1'b0;
         done <= 1'b0;
         acc  <= '0;
      end else if (start) begin
         col  <= '0;
         busy <= 1'b1;
         done <= 1'b0;
         acc  <= '0;
      end else if (busy) begin
         acc <= acc ^ term;
         col <= col + 1'b1;
         if (col == CW'(COLS - 1)) begin
            busy <= 1'b0;
            done <= 1'b1;
         end
      end
   end

   assign s_nat = acc;

endmodule

// File: rtl/tf_h_func.sv
module tf_h_func #(
   parameter logic [8:0] POLY = 9'h169
) (
   input  logic [7:0]  xb,
   input  logic [31:0] l0,
   input  logic [31:0] l1,
   output logic [31:0] z
);
   import tf_ks_pkg::*;

   // per byte lane: which permutation each of the three stages uses (1 = second)
   localparam logic [3:0] SEL_IN  = 4'b1010;
   localparam logic [3:0] SEL_MID = 4'b1100;
   localparam logic [3:0] SEL_OUT = 4'b0101;

   logic [31:0] y;

   generate
      for (genvar ln = 0; ln < 4; ln++) begin : g_lane
         logic [7:0] s1, s2;
         always_comb begin
            s1 = qperm(SEL_IN[ln], xb) ^ l1[ln*8 +: 8];
            s2 = qperm(SEL_MID[ln], s1) ^ l0[ln*8 +: 8];
            y[ln*8 +: 8] = qperm(SEL_OUT[ln], s2);
         end
      end
   endgenerate

   assign z = mds_mix(y, POLY);

endmodule

// File: rtl/tf_pair_gen.sv
module tf_pair_gen #(
   parameter int         IDX_W = 5,
   parameter logic [8:0] POLY  = 9'h169
) (
   input  logic [IDX_W-1:0] idx,
   input  logic [31:0]      ev0,
   input  logic [31:0]      ev1,
   input  logic [31:0]      od0,
   input  logic [31:0]      od1,
   output logic [31:0]      k_even,
   output logic [31:0]      k_odd
);
   import tf_ks_pkg::*;

   generate
      if (IDX_W > 7) begin : g_bad_idx
         $error("tf_pair_gen: h input byte must hold 2*idx+1");
      end
   endgenerate

   logic [31:0] hz [2];

   // half 0 uses the even key words, half 1 the odd key words
   generate
      for (genvar hh = 0; hh < 2; hh++) begin : g_half
         logic [7:0] xb;
         assign xb = 8'({idx, 1'b0}) | 8'(hh);
         tf_h_func #(.POLY(POLY)) u_h (
            .xb (xb),
            .l0 (hh == 0 ? ev0 : od0),
            .l1 (hh == 0 ? ev1 : od1),
            .z  (hz[hh])
         );
      end
   endgenerate

   logic [31:0] a_w, b_w;
   assign a_w    = hz[0];
   assign b_w    = rol32(hz[1], 8);
   assign k_even = a_w + b_w;
   assign k_odd  = rol32(a_w + {b_w[30:0], 1'b0}, 9);

endmodule

// File: rtl/twofish_keysched.sv
module twofish_keysched #(
   parameter int         KEY_BITS  = 128,
   parameter int         NUM_PAIRS = 20,
   parameter int         IDX_W     = 5,
   parameter int         RS_COLS   = 8,
   parameter logic [8:0] RS_POLY   = 9'h14D,
   parameter logic [8:0] MDS_POLY  = 9'h169
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 key_load,
   input  logic [KEY_BITS-1:0]  key_in,
   input  logic                 pair_req,
   input  logic [IDX_W-1:0]     pair_idx,
   output logic [63:0]          pair_out,
   output logic                 pair_vld,
   output logic [KEY_BITS/2-1:0] sbox_words,
   output logic                 sbox_ready
);
   localparam int NSW = KEY_BITS / 64;   // S words
   localparam int NMW = KEY_BITS / 32;   // key words

   generate
      if (KEY_BITS != 128) begin : g_bad_key
         $error("twofish_keysched: only a 128-bit key is supported");
      end
      if (NUM_PAIRS > (1 << IDX_W)) begin : g_bad_pairs
         $error("twofish_keysched: pair index too narrow");
      end
   endgenerate

   logic [KEY_BITS-1:0]  key_q;
   logic [NSW*32-1:0]    s_nat;
   logic                 rs_done;
   logic [31:0]          mw [NMW];
   logic [31:0]          k_even, k_odd;
   logic                 idx_ok, take;

   always_ff @(posedge clk) begin
      if (!rst_n)        key_q <= '0;
      else if (key_load) key_q <= key_in;
   end

   generate
      for (genvar i = 0; i < NMW; i++) begin : g_mword
         assign mw[i] = key_q[i*32 +: 32];
      end
   endgenerate

   tf_rs_serial #(.NWORDS(NSW), .COLS(RS_COLS), .POLY(RS_POLY)) u_rs (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (key_load),
      .key_bytes (key_q),
      .s_nat     (s_nat),
      .done      (rs_done)
   );

   // exported list runs from the last derived word down to the first
   generate
      for (genvar j = 0; j < NSW; j++) begin : g_sord
         assign sbox_words[j*32 +: 32] = s_nat[(NSW - 1 - j)*32 +: 32];
      end
   endgenerate
   assign sbox_ready = rs_done;

   tf_pair_gen #(.IDX_W(IDX_W), .POLY(MDS_POLY)) u_pair (
      .idx    (pair_idx),
      .ev0    (mw[0]),
      .ev1    (mw[2]),
      .od0    (mw[1]),
      .od1    (mw[3]),
      .k_even (k_even),
      .k_odd  (k_odd)
   );

   assign idx_ok = {1'b0, pair_idx} < (IDX_W + 1)'(NUM_PAIRS);
   assign take   = pair_req && rs_done && !key_load && idx_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pair_vld <= 1'b0;
         pair_out <= '0;
      end else begin
         pair_vld <= take;
         if (take) pair_out <= {k_odd, k_even};
      end
   end

endmodule

// File: rtl/tf_ks_checker.sv
module tf_ks_checker #(
   parameter int NUM_PAIRS = 20,
   parameter int IDX_W     = 5,
   parameter int RS_COLS   = 8,
   parameter int SW_BITS   = 64
) (
   input logic               clk,
   input logic               rst_n,
   input logic               key_load,
   input logic               pair_req,
   input logic [IDX_W-1:0]   pair_idx,
   input logic               pair_vld,
   input logic [SW_BITS-1:0] sbox_words,
   input logic               sbox_ready
);
   // cycles since the last load edge, saturating
   logic [5:0] rs_age;
   always_ff @(posedge clk) begin
      if (!rst_n)                           rs_age <= '0;
      else if (key_load)                    rs_age <= 6'd1;
      else if (rs_age != 0 && rs_age != 63) rs_age <= rs_age + 6'd1;
   end

   a_r4_ready_latency: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sbox_ready) |-> rs_age == 6'(RS_COLS + 1));

   a_r5_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
      key_load |=> !sbox_ready && !pair_vld);

   a_r7_no_req_no_vld: assert property (@(posedge clk) disable iff (!rst_n)
      !pair_req |=> !pair_vld);

   a_r8_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
      pair_req && ({1'b0, pair_idx} >= (IDX_W + 1)'(NUM_PAIRS)) |=> !pair_vld);

   a_r9_not_ready_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      !sbox_ready |=> !pair_vld);

   a_r10_sbox_hold: assert property (@(posedge clk) disable iff (!rst_n)
      sbox_ready && !key_load |=> sbox_ready && $stable(sbox_words));

endmodule

bind twofish_keysched tf_ks_checker #(
   .NUM_PAIRS (NUM_PAIRS),
   .IDX_W     (IDX_W),
   .RS_COLS   (RS_COLS),
   .SW_BITS   (KEY_BITS / 2)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .key_load   (key_load),
   .pair_req   (pair_req),
   .pair_idx   (pair_idx),
   .pair_vld   (pair_vld),
   .sbox_words (sbox_words),
   .sbox_ready (sbox_ready)
);

// File: tb/twofish_keysched_test.sv
`timescale 1ns/1ps
module twofish_keysched_test;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         key_load = 1'b0;
   logic [127:0] key_in = '0;
   logic         pair_req = 1'b0;
   logic [4:0]   pair_idx = '0;
   logic [63:0]  pair_out;
   logic         pair_vld;
   logic [63:0]  sbox_words;
   logic         sbox_ready;

   int total = 0;
   int bad   = 0;
   bit done_flag = 1'b0;

   always #2 clk = ~clk;

   twofish_keysched uut (
      .clk(clk), .rst_n(rst_n), .key_load(key_load), .key_in(key_in),
      .pair_req(pair_req), .pair_idx(pair_idx), .pair_out(pair_out),
      .pair_vld(pair_vld), .sbox_words(sbox_words), .sbox_ready(sbox_ready)
   );

   // ---------------- reference model ----------------
   int QT [0:7][0:15] = '{
      '{ 8, 1, 7,13, 6,15, 3, 2, 0,11, 5, 9,14,12,10, 4},
      '{14,12,11, 8, 1, 2, 3, 5,15, 4,10, 6, 7, 0, 9,13},
      '{11,10, 5,14, 6,13, 9, 0,12, 8,15, 3, 2, 4, 7, 1},
      '{13, 7,15, 4, 1, 2, 6,14, 9,11, 3, 0, 8, 5,12,10},
      '{ 2, 8,11,13,15, 7, 6,14, 3, 1, 9, 4, 0,10,12, 5},
      '{ 1,14, 2,11, 4,12, 3, 7, 6,13,10, 5,15, 9, 0, 8},
      '{ 4,12, 7, 5, 1, 6, 9,10, 0,14,13, 8, 2,11, 3,15},
      '{11, 9, 5, 1,12, 3,13,14, 6, 4, 7,15, 2, 0, 8,10}};

   int RSM [0:3][0:7] = '{
      '{'h01,'hA4,'h55,'h87,'h5A,'h58,'hDB,'h9E},
      '{'hA4,'h56,'h82,'hF3,'h1E,'hC6,'h68,'hE5},
      '{'h02,'hA1,'hFC,'hC1,'h47,'hAE,'h3D,'h19},
      '{'hA4,'h55,'h87,'h5A,'h58,'hDB,'h9E,'h03}};

   int MDM [0:3][0:3] = '{
      '{'h01,'hEF,'h5B,'h5B},
      '{'h5B,'hEF,'hEF,'h01},
      '{'hEF,'h5B,'h01,'hEF},
      '{'hEF,'h01,'hEF,'h5B}};

   function automatic int gm(int a, int b, int poly);
      int r = 0;
      for (int i = 0; i < 8; i++) begin
         if ((b >> i) & 1) r ^= a;
         a = a << 1;
         if (a & 256) a ^= poly;
      end
      return r & 255;
   endfunction

   function automatic int rq(int s, int x);
      int a0 = (x >> 4) & 15, b0 = x & 15, a1, b1, a2, b2, a3, b3;
      a1 = a0 ^ b0;
      b1 = (a0 ^ (((b0 >> 1) | (b0 << 3)) & 15) ^ ((a0 << 3) & 15)) & 15;
      a2 = QT[4*s+0][a1];
      b2 = QT[4*s+1][b1];
      a3 = a2 ^ b2;
      b3 = (a2 ^ (((b2 >> 1) | (b2 << 3)) & 15) ^ ((a2 << 3) & 15)) & 15;
      return (QT[4*s+3][b3] << 4) | QT[4*s+2][a3];
   endfunction

   function automatic logic [31:0] rh(int x, logic [31:0] l0, logic [31:0] l1);
      int y [0:3];
      logic [31:0] z = '0;
      y[0] = rq(1, rq(0, rq(0, x) ^ l1[7:0])   ^ l0[7:0]);
      y[1] = rq(0, rq(0, rq(1, x) ^ l1[15:8])  ^ l0[15:8]);
      y[2] = rq(1, rq(1, rq(0, x) ^ l1[23:16]) ^ l0[23:16]);
      y[3] = rq(0, rq(1, rq(1, x) ^ l1[31:24]) ^ l0[31:24]);
      for (int r = 0; r < 4; r++) begin
         int acc = 0;
         for (int c = 0; c < 4; c++) acc ^= gm(MDM[r][c], y[c], 'h169);
         z[8*r +: 8] = 8'(acc);
      end
      return z;
   endfunction

   function automatic logic [31:0] rl(logic [31:0] v, int n);
      return (v << n) | (v >> (32 - n));
   endfunction

   function automatic logic [31:0] mword(logic [127:0] k, int i);
      return k[32*i +: 32];
   endfunction

   function automatic logic [63:0] ref_pair(logic [127:0] k, int i);
      logic [31:0] a, b;
      a = rh(2*i, mword(k, 0), mword(k, 2));
      b = rl(rh(2*i + 1, mword(k, 1), mword(k, 3)), 8);
      return {rl(a + 2*b, 9), a + b};
   endfunction

   function automatic logic [63:0] ref_sbox(logic [127:0] k);
      logic [31:0] s [0:1];
      for (int w = 0; w < 2; w++) begin
         s[w] = '0;
         for (int r = 0; r < 4; r++) begin
            int acc = 0;
            for (int c = 0; c < 8; c++) acc ^= gm(RSM[r][c], int'(k[8*(8*w + c) +: 8]), 'h14D);
            s[w][8*r +: 8] = 8'(acc);
         end
      end
      return {s[0], s[1]};
   endfunction

   // ---------------- helpers ----------------
   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // load and check the ready latency (R4)
   task automatic load_timed(input logic [127:0] k, input string tag);
      int early = 0;
      @(negedge clk); key_load = 1'b1; key_in = k;
      @(negedge clk); key_load = 1'b0;
      for (int c = 0; c < 8; c++) begin
         if (sbox_ready) early++;
         if (c < 7) @(negedge clk);
      end
      chk({tag, " ready low during derivation"}, 64'(early), 64'd0);
      @(negedge clk);
      chk({tag, " ready at eighth edge"}, 64'(sbox_ready), 64'd1);
   endtask

   task automatic req_pair(input logic [127:0] k, input int i, input string tag);
      @(negedge clk); pair_req = 1'b1; pair_idx = 5'(i);
      @(negedge clk); pair_req = 1'b0;
      chk({tag, " valid"}, 64'(pair_vld), 64'd1);
      chk({tag, " pair value"}, pair_out, ref_pair(k, i));
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      chk("R1 ready after reset", 64'(sbox_ready), 64'd0);
      chk("R1 valid after reset", 64'(pair_vld), 64'd0);
   endtask

   task automatic t_key(input logic [127:0] k);
      load_timed(k, "R4");
      chk("R3 S words", sbox_words, ref_sbox(k));
      req_pair(k, 0, "R6 pair 0");
      req_pair(k, 1, "R6 pair 1");
      req_pair(k, 4, "R2 pair 4");
      req_pair(k, 19, "R6 last pair");
      @(negedge clk);
      chk("R7 idle no valid", 64'(pair_vld), 64'd0);
   endtask

   task automatic t_range();
      @(negedge clk); pair_req = 1'b1; pair_idx = 5'd20;
      @(negedge clk);
      chk("R8 index 20", 64'(pair_vld), 64'd0);
      pair_idx = 5'd31;
      @(negedge clk); pair_req = 1'b0;
      chk("R8 index 31", 64'(pair_vld), 64'd0);
   endtask

   task automatic t_busy(input logic [127:0] k);
      @(negedge clk); key_load = 1'b1; key_in = k; pair_req = 1'b1; pair_idx = 5'd3;
      @(negedge clk); key_load = 1'b0;
      chk("R9 request with load", 64'(pair_vld), 64'd0);
      @(negedge clk);
      chk("R9 request while deriving", 64'(pair_vld), 64'd0);
      pair_req = 1'b0;
      repeat (8) @(negedge clk);
      chk("R9 ready after wait", 64'(sbox_ready), 64'd1);
      req_pair(k, 3, "R9 pair after ready");
   endtask

   task automatic t_abort(input logic [127:0] ka, input logic [127:0] kb);
      @(negedge clk); key_load = 1'b1; key_in = ka;
      @(negedge clk); key_load = 1'b0;
      repeat (3) @(negedge clk);
      load_timed(kb, "R5 restart R4");
      chk("R5 S words of newest key", sbox_words, ref_sbox(kb));
      req_pair(kb, 7, "R5 pair of newest key");
   endtask

   task automatic t_hold();
      logic [63:0] snap = sbox_words;
      for (int c = 0; c < 6; c++) begin
         @(negedge clk); pair_req = c[0]; pair_idx = 5'(c * 5);
      end
      @(negedge clk); pair_req = 1'b0;
      chk("R10 S words held", sbox_words, snap);
      chk("R10 still ready", 64'(sbox_ready), 64'd1);
   endtask

   // ---------------- main ----------------
   initial begin
      logic [127:0] walk;
      for (int n = 0; n < 16; n++) walk[8*n +: 8] = 8'(16 * n + 15 - n);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_key(128'h0);
      t_key(walk);
      t_key(128'hFEDCBA98_76543210_01234567_89ABCDEF);
      t_range();
      t_busy(128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0);
      t_abort(128'h11111111_22222222_33333333_44444444, walk ^ 128'h5A);
      t_hold();
      done_flag = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done_flag) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule